// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration front end of a two-channel disk controller. It sits behind a four-offset I/O window and is driven by simple one-cycle access strobes. A byte-wide pointer register chooses one of two channel banks and a register index within that bank. A 16-bit data port then reads or writes the chosen register. When the pointer's advance bit is set, the index steps after every data-port access, so a run of back-to-back accesses walks through consecutive registers.

The same window also holds two other registers. The first shares one offset between a write-only test/mode register and a read-only status byte. The second is an interrupt mask register that also shows channel-1 status and a strap input. Per-channel drive and bus-master interrupt status arrive from outside the block. They are combined and gated by the mask bits to form one interrupt output per channel.

Top module: `cfg_indexed_port`

Offsets used by the bench: 0 is the data port, 1 the pointer, 2 test (write) / status (read), 3 the mask.

## Requirements
- R1: After reset, the pointer reads 0x40, the mask bits and the test register are 0, and every indexed register reads 0.
- R2: A write to offset 1 stores pointer bits 7 (advance), 6 (posted-write wait), 5 (burst disable), 3 (bank) and 2:0 (index). A read of offset 1 returns bits 7, 6, 3 and 2:0, with bits 5 and 4 reading 0. Bit 5 drives `burst_off` and bit 6 drives `post_wait`.
- R3: A write to offset 0 stores the 16-bit value in the register chosen by the pointer's bank bit and index. A read of offset 0 returns that register's value in the same cycle.
- R4: When pointer bit 7 is 1, the index is one higher, modulo 8, on the clock edge that ends each offset-0 access (read or write). The other pointer bits stay as they were.
- R5: When pointer bit 7 is 0, offset-0 accesses leave the pointer unchanged.
- R6: Index 7 of either bank reads 0, and a write to it changes no register.
- R7: A write to offset 2 stores bit 1 as `legacy_mode` and bit 0 as `test_mode`. A read of offset 2 returns channel-0 bus-master status in bit 1 and channel-0 drive status in bit 0; all other bits read 0.
- R8: A write to offset 3 stores only bits 1:0 (the channel masks). A read returns the masks in bits 1:0, channel-1 drive status in bit 2, channel-1 bus-master status in bit 3 and the legacy-header strap in bit 4; all other bits read 0.
- R9: `irq_out[c]` is 1 exactly when channel c's drive or bus-master status is 1 and its mask bit is 0.
- R10: No register changes in a cycle where `acc_en` is 0, and `rdata` is 0 in any cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 2 | Window offset |
| wdata | input | 16 | Write data (byte registers use bits 7:0) |
| rdata | output | 16 | Read data, valid in the access cycle |
| ch_drv_irq | input | 2 | Per-channel drive interrupt status |
| ch_bm_irq | input | 2 | Per-channel bus-master interrupt status |
| legacy_hdr | input | 1 | Legacy-header strap |
| burst_off | output | 1 | Pointer bit 5 |
| post_wait | output | 1 | Pointer bit 6 |
| legacy_mode | output | 1 | Test register bit 1 |
| test_mode | output | 1 | Test register bit 0 |
| irq_out | output | 2 | Masked per-channel interrupt |

## Verification
Read data and the interrupt outputs are combinational. The bench therefore samples them in the access cycle itself, a short delay after driving the inputs and before the closing edge. Register updates, including the index advance, land on that edge. Their effects (mode outputs, pointer readback, the next register reached) are checked from the following cycle onward, after the bench has applied the same update to its model. With zero latency on reads and one edge on writes, each expected value is formed from the model state as it stands before that cycle's update.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int N_CH    = 2;
    localparam int N_REGS  = 7;
    localparam int IDX_W   = 3;
    localparam int OFF_W   = 2;
    localparam int BANK_W  = $clog2(N_CH);

    localparam logic [OFF_W-1:0] OFF_DATA = 2'd0;
    localparam logic [OFF_W-1:0] OFF_PTR  = 2'd1;
    localparam logic [OFF_W-1:0] OFF_STAT = 2'd2;
    localparam logic [OFF_W-1:0] OFF_MASK = 2'd3;

    typedef struct packed {
        logic             adv;
        logic             wait1;
        logic             burst_off;
        logic             rsvd;
        logic             bank;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    localparam ptr_t PTR_RESET = '{adv: 1'b0, wait1: 1'b1, burst_off: 1'b0,
                                   rsvd: 1'b0, bank: 1'b0, idx: '0};

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE
    } acc_kind_e;

    function automatic ptr_t ptr_load(input logic [BYTE_W-1:0] b);
        ptr_t p;
        p = ptr_t'(b);
        p.rsvd = 1'b0;
        return p;
    endfunction

    function automatic logic [BYTE_W-1:0] ptr_view(input ptr_t p);
        ptr_t v;
        v = p;
        v.burst_off = 1'b0;
        v.rsvd = 1'b0;
        return BYTE_W'(v);
    endfunction
endpackage

// File: rtl/cfgp_ptr_unit.sv
module cfgp_ptr_unit
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_we,
    input  logic [BYTE_W-1:0] ptr_wdata,
    input  logic              data_acc,
    output ptr_t              ptr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= PTR_RESET;
        end else if (ptr_we) begin
            ptr_q <= ptr_load(ptr_wdata);
        end else if (data_acc && ptr_q.adv) begin
            ptr_q.idx <= ptr_q.idx + 1'b1;
        end
    end
endmodule

// File: rtl/cfgp_bank_file.sv
module cfgp_bank_file
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              bank,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] regs [N_CH][N_REGS];
    logic [DATA_W-1:0] ch_word [N_CH];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        for (genvar i = 0; i < N_REGS; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[c][i] <= '0;
                end else if (we && (BANK_W'(bank) == BANK_W'(c)) &&
                             (idx == IDX_W'(i))) begin
                    regs[c][i] <= wdata;
                end
            end
        end

        always_comb begin
            ch_word[c] = '0;
            for (int i = 0; i < N_REGS; i++) begin
                if (idx == IDX_W'(i)) ch_word[c] = regs[c][i];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (BANK_W'(bank) == BANK_W'(c)) rd_word = ch_word[c];
        end
    end
endmodule

// File: rtl/cfgp_ctl_regs.sv
module cfgp_ctl_regs
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_we,
    input  logic              mask_we,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [N_CH-1:0]   ch_drv_irq,
    input  logic [N_CH-1:0]   ch_bm_irq,
    input  logic              legacy_hdr,
    output logic [1:0]        test_q,
    output logic [N_CH-1:0]   mask_q,
    output logic [BYTE_W-1:0] stat_byte,
    output logic [BYTE_W-1:0] mask_byte,
    output logic [N_CH-1:0]   irq_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            test_q <= '0;
            mask_q <= '0;
        end else begin
            if (test_we) test_q <= wbyte[1:0];
            if (mask_we) mask_q <= wbyte[N_CH-1:0];
        end
    end

    always_comb begin
        stat_byte    = '0;
        stat_byte[0] = ch_drv_irq[0];
        stat_byte[1] = ch_bm_irq[0];
        mask_byte    = '0;
        mask_byte[N_CH-1:0] = mask_q;
        mask_byte[2] = ch_drv_irq[1];
        mask_byte[3] = ch_bm_irq[1];
        mask_byte[4] = legacy_hdr;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_irq
        assign irq_out[c] = (ch_drv_irq[c] | ch_bm_irq[c]) & ~mask_q[c];
    end
endmodule

// File: rtl/cfg_indexed_port.sv
module cfg_indexed_port
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [1:0]        acc_off,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic [1:0]        ch_drv_irq,
    input  logic [1:0]        ch_bm_irq,
    input  logic              legacy_hdr,
    output logic              burst_off,
    output logic              post_wait,
    output logic              legacy_mode,
    output logic              test_mode,
    output logic [1:0]        irq_out
);
    acc_kind_e         kind;
    ptr_t              ptr_q;
    logic [1:0]        test_q;
    logic [N_CH-1:0]   mask_q;
    logic [BYTE_W-1:0] stat_byte;
    logic [BYTE_W-1:0] mask_byte;
    logic [DATA_W-1:0] bank_word;
    logic              data_acc;

    always_comb begin
        if (!acc_en)     kind = ACC_NONE;
        else if (acc_wr) kind = ACC_WRITE;
        else             kind = ACC_READ;
    end

    assign data_acc = (kind != ACC_NONE) && (acc_off == OFF_DATA);

    cfgp_ptr_unit u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ptr_we    ((kind == ACC_WRITE) && (acc_off == OFF_PTR)),
        .ptr_wdata (wdata[BYTE_W-1:0]),
        .data_acc  (data_acc),
        .ptr_q     (ptr_q)
    );

    cfgp_bank_file u_banks (
        .clk     (clk),
        .rst     (rst),
        .we      ((kind == ACC_WRITE) && (acc_off == OFF_DATA)),
        .bank    (ptr_q.bank),
        .idx     (ptr_q.idx),
        .wdata   (wdata),
        .rd_word (bank_word)
    );

    cfgp_ctl_regs u_ctl (
        .clk        (clk),
        .rst        (rst),
        .test_we    ((kind == ACC_WRITE) && (acc_off == OFF_STAT)),
        .mask_we    ((kind == ACC_WRITE) && (acc_off == OFF_MASK)),
        .wbyte      (wdata[BYTE_W-1:0]),
        .ch_drv_irq (ch_drv_irq),
        .ch_bm_irq  (ch_bm_irq),
        .legacy_hdr (legacy_hdr),
        .test_q     (test_q),
        .mask_q     (mask_q),
        .stat_byte  (stat_byte),
        .mask_byte  (mask_byte),
        .irq_out    (irq_out)
    );

    always_comb begin
        rdata = '0;
        if (kind == ACC_READ) begin
            unique case (acc_off)
                OFF_DATA: rdata = bank_word;
                OFF_PTR:  rdata = DATA_W'(ptr_view(ptr_q));
                OFF_STAT: rdata = DATA_W'(stat_byte);
                OFF_MASK: rdata = DATA_W'(mask_byte);
                default:  rdata = '0;
            endcase
        end
    end

    assign burst_off   = ptr_q.burst_off;
    assign post_wait   = ptr_q.wait1;
    assign legacy_mode = test_q[1];
    assign test_mode   = test_q[0];
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [1:0]  acc_off,
    input logic [15:0] rdata,
    input logic [1:0]  ch_drv_irq,
    input logic [1:0]  ch_bm_irq,
    input logic [1:0]  irq_out,
    input ptr_t        ptr_q,
    input logic [1:0]  mask_q
);
    // R4: the index steps by one after a data access while advance is set
    assert_autoinc_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_off == OFF_DATA && ptr_q.adv)
        |=> (ptr_q.idx == $past(ptr_q.idx) + 3'd1));

    // R5: no step while advance is clear
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_off == OFF_DATA && !ptr_q.adv) |=> $stable(ptr_q));

    // R6: index 7 reads zero
    assert_idx7_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && acc_off == OFF_DATA && ptr_q.idx == 3'd7)
        |-> (rdata == 16'h0));

    // R7: status read shows channel-0 lines only
    assert_status_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && acc_off == OFF_STAT)
        |-> (rdata == {14'h0, ch_bm_irq[0], ch_drv_irq[0]}));

    // R9: a masked channel never interrupts, an unmasked active one does
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        mask_q[0] |-> !irq_out[0]);
    assert_irq_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (!mask_q[1] && (ch_drv_irq[1] || ch_bm_irq[1])) |-> irq_out[1]);

    // R10: idle cycles change nothing and return zero
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> ($stable(ptr_q) && $stable(mask_q)));
    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> (rdata == 16'h0));
endmodule

bind cfg_indexed_port cfgp_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_off    (acc_off),
    .rdata      (rdata),
    .ch_drv_irq (ch_drv_irq),
    .ch_bm_irq  (ch_bm_irq),
    .irq_out    (irq_out),
    .ptr_q      (ptr_q),
    .mask_q     (mask_q)
);

// File: tb/cfg_indexed_port_tb.sv
`timescale 1ns/1ps
module cfg_indexed_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_off = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [1:0]  ch_drv_irq = 2'b0;
    logic [1:0]  ch_bm_irq = 2'b0;
    logic        legacy_hdr = 1'b0;
    logic        burst_off, post_wait, legacy_mode, test_mode;
    logic [1:0]  irq_out;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [7:0]  m_ptr;
    logic [15:0] m_reg [2][8];
    logic [1:0]  m_test;
    logic [1:0]  m_mask;

    always #10 clk = ~clk;

    cfg_indexed_port dut_i (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_off(acc_off), .wdata(wdata), .rdata(rdata),
        .ch_drv_irq(ch_drv_irq), .ch_bm_irq(ch_bm_irq), .legacy_hdr(legacy_hdr),
        .burst_off(burst_off), .post_wait(post_wait),
        .legacy_mode(legacy_mode), .test_mode(test_mode), .irq_out(irq_out)
    );

    task automatic check(input logic ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [1:0] off);
        logic [2:0] ix;
        ix = m_ptr[2:0];
        case (off)
            2'd0: exp_read = (ix == 3'd7) ? 16'h0 : m_reg[m_ptr[3]][ix];
            2'd1: exp_read = {8'h0, m_ptr & 8'hCF};
            2'd2: exp_read = {14'h0, ch_bm_irq[0], ch_drv_irq[0]};
            default: exp_read = {11'h0, legacy_hdr, ch_bm_irq[1], ch_drv_irq[1], m_mask};
        endcase
    endfunction

    function automatic logic [1:0] exp_irq();
        exp_irq = (ch_drv_irq | ch_bm_irq) & ~m_mask;
    endfunction

    task automatic model_update(input logic en, input logic wr,
                                input logic [1:0] off, input logic [15:0] d);
        if (!en) return;
        case (off)
            2'd0: begin
                if (wr && m_ptr[2:0] != 3'd7) m_reg[m_ptr[3]][m_ptr[2:0]] = d;
                if (m_ptr[7]) m_ptr[2:0] = m_ptr[2:0] + 3'd1;
            end
            2'd1: if (wr) m_ptr = d[7:0] & 8'hEF;
            2'd2: if (wr) m_test = d[1:0];
            default: if (wr) m_mask = d[1:0];
        endcase
    endtask

    // one access cycle; read data and irq are sampled inside it
    task automatic access(input logic en, input logic wr, input logic [1:0] off,
                          input logic [15:0] d, input string req);
        logic [15:0] e;
        @(negedge clk);
        acc_en = en; acc_wr = wr; acc_off = off; wdata = d;
        #2;
        e = (en && !wr) ? exp_read(off) : 16'h0;
        check(rdata === e, (en && !wr) ? req : "R10 rdata", rdata, e);
        check(irq_out === exp_irq(), "R9 irq", {14'h0, irq_out}, {14'h0, exp_irq()});
        @(posedge clk);
        model_update(en, wr, off, d);
        #1;
        acc_en = 1'b0;
        check({burst_off, post_wait} === {m_ptr[5], m_ptr[6]}, "R2 ptr outs",
              {14'h0, burst_off, post_wait}, {14'h0, m_ptr[5], m_ptr[6]});
        check({legacy_mode, test_mode} === m_test, "R7 mode outs",
              {14'h0, legacy_mode, test_mode}, {14'h0, m_test});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_ptr = 8'h40; m_test = 2'b0; m_mask = 2'b0;
        for (int c = 0; c < 2; c++) for (int i = 0; i < 8; i++) m_reg[c][i] = 16'h0;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        access(1'b1, 1'b0, 2'd1, 16'h0, "R1 ptr reset");
        access(1'b1, 1'b0, 2'd3, 16'h0, "R1 mask reset");
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 8; i++) begin
                access(1'b1, 1'b1, 2'd1, 16'(c * 8 + i), "R2");
                access(1'b1, 1'b0, 2'd0, 16'h0, "R1 regs reset");
            end
        end

        // R4/R6: advance through bank 0, write 8 words, wraps and reads back
        access(1'b1, 1'b1, 2'd1, 16'h0080, "R2");
        for (int i = 0; i < 8; i++) access(1'b1, 1'b1, 2'd0, 16'hA000 + 16'(i), "R4");
        access(1'b1, 1'b0, 2'd1, 16'h0, "R4 wrap");
        for (int i = 0; i < 8; i++) access(1'b1, 1'b0, 2'd0, 16'h0, "R6 R3 readback");

        // R5: no advance on bank 1 index 2
        access(1'b1, 1'b1, 2'd1, 16'h000A, "R2");
        access(1'b1, 1'b1, 2'd0, 16'h1234, "R3");
        access(1'b1, 1'b1, 2'd0, 16'h5678, "R3");
        access(1'b1, 1'b0, 2'd1, 16'h0, "R5 ptr hold");
        access(1'b1, 1'b0, 2'd0, 16'h0, "R5 last write kept");

        // R2: reserved and write-only pointer bits
        access(1'b1, 1'b1, 2'd1, 16'hFFFF, "R2");
        access(1'b1, 1'b0, 2'd1, 16'h0, "R2 readback");

        // R8/R9: masks with active status lines
        ch_drv_irq = 2'b11; ch_bm_irq = 2'b10; legacy_hdr = 1'b1;
        access(1'b1, 1'b1, 2'd3, 16'hFFFE, "R8");
        access(1'b1, 1'b0, 2'd3, 16'h0, "R8 mask read");
        access(1'b1, 1'b0, 2'd2, 16'h0, "R7 status read");

        // R10: idle strobes with write intent change nothing
        access(1'b0, 1'b1, 2'd3, 16'h0003, "R10");
        access(1'b0, 1'b1, 2'd1, 16'h0000, "R10");
        access(1'b1, 1'b0, 2'd3, 16'h0, "R10 mask unchanged");
        access(1'b1, 1'b0, 2'd1, 16'h0, "R10 ptr unchanged");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            logic [1:0]  off;
            logic [15:0] d;
            logic        en, wr;
            en = ($urandom % 8) != 0;
            wr = $urandom % 2;
            off = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
            d = 16'($urandom);
            ch_drv_irq = 2'($urandom);
            ch_bm_irq = 2'($urandom);
            legacy_hdr = 1'($urandom);
            access(en, wr, off, d, "R3 R4 R7 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule